// File: doc/BRIEF.md
# Infrared SIR Pulse Codec

This block sits between a UART and an infrared transceiver. On the transmit side it turns the UART's NRZ serial output into short, active-high light pulses, one for every logic-0 bit, start bit included. On the receive side it turns each incoming light pulse back into a logic-0 level that lasts one bit period, which a standard UART receiver can sample. Timing comes from the peripheral clock and a one-cycle enable tick that runs at 16 times the baud rate. A bit period is 16 such ticks.

The pulse width has two settings. The default is 3/16 of a bit period. The other is a fixed width of 2^(sel+1) peripheral-clock cycles, set by a 3-bit selector, so that the pulse can be held above the optical minimum at any baud rate. An inversion control flips the incoming line only. With the enable control low, the block is a plain wire in both directions. Changing the controls while a frame is in flight is not supported.

Transmit state machine: TX_IDLE (output low, waiting for a tick with the line low), TX_PULSE (output high) and TX_REST (output low for the rest of a zero bit). These transitions exist:
- TX_IDLE to TX_PULSE on a tick with the UART line low.
- TX_PULSE to TX_REST when the width is used up.
- TX_PULSE or TX_REST to TX_PULSE at a bit boundary with the line low.
- TX_PULSE or TX_REST to TX_IDLE at a bit boundary with the line high.

Receive state machine: RX_IDLE (output high) and RX_LOW (output low). RX_IDLE goes to RX_LOW on a synchronized rising edge. RX_LOW restarts itself on a new edge. RX_LOW returns to RX_IDLE after 16 ticks.

Top module: `irda_sir_codec`

## Requirements
- R1: With cfg_enable=0, ir_txd_out equals uart_txd and uart_rxd equals ir_rxd_in in the same cycle, for either value of cfg_rx_invert.
- R2: During and after reset, with cfg_enable=1, uart_txd high and an idle receive line, ir_txd_out is 0 and uart_rxd is 1.
- R3: A pulse is sent only for a zero bit. A bit whose uart_txd is 1 at its first tick keeps ir_txd_out low for the whole bit. A zero bit's pulse rises one clock after the clock edge that carries the bit's first tick.
- R4: With cfg_fixed_pulse=0, each pulse lasts exactly 3 tick intervals.
- R5: With cfg_fixed_pulse=1, each pulse lasts 2^(cfg_pulse_sel+1) clock cycles (2 for code 0 up to 256 for code 7), as long as that is shorter than 15 tick intervals.
- R6: A fixed pulse that would pass 15 tick intervals is cut off at the 15th tick of its bit. Back-to-back zero bits therefore always give separate pulses, with a low gap in between.
- R7: cfg_rx_invert=1 flips the received line before detection and leaves the transmitted pulses unchanged.
- R8: A rising edge on the (possibly inverted) receive line drives uart_rxd low 3 clocks later, through two synchronizer stages and an edge stage. uart_rxd then stays low for 16 ticks.
- R9: A new rising edge that arrives while uart_rxd is low restarts the 16-tick low window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable at 16x the baud rate |
| uart_txd | input | 1 | NRZ serial data from the UART transmitter |
| ir_rxd_in | input | 1 | Raw line from the infrared receiver |
| cfg_enable | input | 1 | 1 = pulse coding, 0 = pass-through |
| cfg_rx_invert | input | 1 | Invert the receive line |
| cfg_fixed_pulse | input | 1 | 1 = fixed clock-count pulse width |
| cfg_pulse_sel | input | 3 | Fixed width select, width 2^(sel+1) clocks |
| ir_txd_out | output | 1 | Active-high pulse to the infrared emitter |
| uart_rxd | output | 1 | Recovered NRZ data for the UART receiver |

## Verification
The pass-through path is combinational, so it is checked 1 ns after the inputs change. On transmit, a zero bit's pulse is sampled from the cycle after its first tick. Its length is then counted in clock cycles and compared with 3 ticks, with 2^(sel+1) clocks, or with the 15-tick cap. On receive, the recovered line is expected to fall exactly 3 cycles after the injected edge. The length of the low run is counted in ticks, with the tick held high on every cycle so that the count is exact. Inputs are driven at falling clock edges and outputs are logged at those same edges, so each logged value reflects the rising edge just before it.

// File: rtl/irda_pkg.sv
package irda_pkg;

    typedef enum logic [1:0] {
        TX_IDLE  = 2'd0,
        TX_PULSE = 2'd1,
        TX_REST  = 2'd2
    } tx_state_e;

    typedef enum logic {
        RX_IDLE = 1'b0,
        RX_LOW  = 1'b1
    } rx_state_e;

endpackage

// File: rtl/irda_tx_pulser.sv
module irda_tx_pulser
    import irda_pkg::*;
#(
    parameter int BIT_TICKS  = 16,
    parameter int NORM_TICKS = 3,
    parameter int PDIV_W     = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              tick_i,
    input  logic              txd_i,
    input  logic              fixed_i,
    input  logic [PDIV_W-1:0] sel_i,
    output logic              pulse_o
);
    localparam int PH_W  = $clog2(BIT_TICKS);
    localparam int LIM_W = (1 << PDIV_W) + 1;

    tx_state_e        state_q, state_d;
    logic [PH_W-1:0]  phase_q, phase_d, nxt_ph;
    logic [LIM_W-1:0] wcnt_q, wcnt_d, wlim;
    logic             last_tick, cut, width_done;

    // fixed width limit: 2^(sel+1) - 1 cycles after the first
    assign wlim = (LIM_W'(1) << ({1'b0, sel_i} + 1'b1)) - LIM_W'(1);

    always_comb begin
        state_d    = state_q;
        phase_d    = phase_q;
        wcnt_d     = wcnt_q;
        nxt_ph     = phase_q + PH_W'(1);
        last_tick  = tick_i && (phase_q == PH_W'(BIT_TICKS - 1));
        width_done = fixed_i && (wcnt_q == wlim);
        cut        = tick_i && ((nxt_ph == PH_W'(BIT_TICKS - 1)) ||
                                (!fixed_i && nxt_ph == PH_W'(NORM_TICKS)));
        unique case (state_q)
            TX_IDLE: begin
                if (tick_i && !txd_i) begin
                    state_d = TX_PULSE;
                    phase_d = '0;
                    wcnt_d  = '0;
                end
            end
            TX_PULSE: begin
                if (last_tick) begin
                    state_d = txd_i ? TX_IDLE : TX_PULSE;
                    phase_d = '0;
                    wcnt_d  = '0;
                end else begin
                    if (tick_i) phase_d = nxt_ph;
                    if (cut || width_done) state_d = TX_REST;
                    else                   wcnt_d  = wcnt_q + LIM_W'(1);
                end
            end
            TX_REST: begin
                if (last_tick) begin
                    state_d = txd_i ? TX_IDLE : TX_PULSE;
                    phase_d = '0;
                    wcnt_d  = '0;
                end else if (tick_i) begin
                    phase_d = nxt_ph;
                end
            end
            default: state_d = TX_IDLE;
        endcase
        if (!en_i) begin
            state_d = TX_IDLE;
            phase_d = '0;
            wcnt_d  = '0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= TX_IDLE;
            phase_q <= '0;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            wcnt_q  <= wcnt_d;
        end
    end

    always_comb begin
        pulse_o = (state_q == TX_PULSE);
    end

    AST_PULSE_FROM_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pulse_o) |-> ($past(tick_i) && !$past(txd_i))); // R3
    AST_NORMAL_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!fixed_i && state_q == TX_PULSE) |-> (phase_q < PH_W'(NORM_TICKS))); // R4
    AST_GAP_AT_BIT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != TX_IDLE && phase_q == PH_W'(BIT_TICKS - 1)) |-> !pulse_o); // R6

endmodule

// File: rtl/irda_rx_stretcher.sv
module irda_rx_stretcher
    import irda_pkg::*;
#(
    parameter int BIT_TICKS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic tick_i,
    input  logic line_i,
    output logic rxd_o
);
    localparam int CNT_W = $clog2(BIT_TICKS);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q, edge_w;
    rx_state_e              state_q, state_d;
    logic [CNT_W-1:0]       cnt_q, cnt_d;

    assign edge_w = sync_q[SYNC_STAGES-1] && !prev_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            RX_IDLE: begin
                if (edge_w) begin
                    state_d = RX_LOW;
                    cnt_d   = '0;
                end
            end
            RX_LOW: begin
                if (edge_w) begin
                    cnt_d = '0;
                end else if (tick_i) begin
                    if (cnt_q == CNT_W'(BIT_TICKS - 1)) state_d = RX_IDLE;
                    else                               cnt_d   = cnt_q + CNT_W'(1);
                end
            end
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else if (!en_i) begin
            sync_q  <= '0;
            prev_q  <= 1'b0;
            state_q <= RX_IDLE;
            cnt_q   <= '0;
        end else begin
            sync_q  <= {sync_q[SYNC_STAGES-2:0], line_i};
            prev_q  <= sync_q[SYNC_STAGES-1];
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        rxd_o = (state_q != RX_LOW);
    end

    AST_EDGE_PULLS_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && edge_w) |=> (!en_i || !rxd_o)); // R8
    AST_RX_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && edge_w && state_q == RX_LOW) |=> (!en_i || cnt_q == '0)); // R9

endmodule

// File: rtl/irda_sir_codec.sv
module irda_sir_codec #(
    parameter int BIT_TICKS  = 16,
    parameter int NORM_TICKS = 3,
    parameter int PDIV_W     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              uart_txd,
    input  logic              ir_rxd_in,
    input  logic              cfg_enable,
    input  logic              cfg_rx_invert,
    input  logic              cfg_fixed_pulse,
    input  logic [PDIV_W-1:0] cfg_pulse_sel,
    output logic              ir_txd_out,
    output logic              uart_rxd
);
    logic tx_pulse, rx_nrz, rx_line;

    assign rx_line = ir_rxd_in ^ cfg_rx_invert;

    irda_tx_pulser #(
        .BIT_TICKS (BIT_TICKS),
        .NORM_TICKS(NORM_TICKS),
        .PDIV_W    (PDIV_W)
    ) u_tx (
        .clk_i  (clk),
        .rst_ni (rst_n),
        .en_i   (cfg_enable),
        .tick_i (tick16),
        .txd_i  (uart_txd),
        .fixed_i(cfg_fixed_pulse),
        .sel_i  (cfg_pulse_sel),
        .pulse_o(tx_pulse)
    );

    irda_rx_stretcher #(
        .BIT_TICKS  (BIT_TICKS),
        .SYNC_STAGES(2)
    ) u_rx (
        .clk_i (clk),
        .rst_ni(rst_n),
        .en_i  (cfg_enable),
        .tick_i(tick16),
        .line_i(rx_line),
        .rxd_o (rx_nrz)
    );

    always_comb begin
        ir_txd_out = cfg_enable ? tx_pulse : uart_txd;
        uart_rxd   = cfg_enable ? rx_nrz   : ir_rxd_in;
    end

endmodule

// File: tb/tb_irda_sir_codec.sv
module tb_irda_sir_codec;
    localparam int TP  = 4;
    localparam int BTK = 16;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, tick16, uart_txd, ir_rxd_in;
    logic cfg_enable, cfg_rx_invert, cfg_fixed_pulse;
    logic [2:0] cfg_pulse_sel;
    logic ir_txd_out, uart_rxd;

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    logic rec [0:1023];

    irda_sir_codec dut (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .uart_txd(uart_txd),
        .ir_rxd_in(ir_rxd_in), .cfg_enable(cfg_enable),
        .cfg_rx_invert(cfg_rx_invert), .cfg_fixed_pulse(cfg_fixed_pulse),
        .cfg_pulse_sel(cfg_pulse_sel), .ir_txd_out(ir_txd_out),
        .uart_rxd(uart_rxd)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int got, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s got=%0d exp=%0d", req, what, got, exp);
        end
    endtask

    task automatic report();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired got=%0d exp=%0d", cyc, 150000);
            report();
        end
    end

    // one 10-bit frame, LSB first (bit 0 = start), ticks every TP clocks
    task automatic tx_frame(input logic [9:0] fr, input bit fx, input int sel,
                            input bit inv);
        int n = 10 * BTK * TP + 20;
        int len_exp;
        string req;
        @(negedge clk);
        cfg_fixed_pulse = fx; cfg_pulse_sel = 3'(sel);
        cfg_rx_invert = inv; ir_rxd_in = inv; uart_txd = 1'b1; tick16 = 1'b0;
        repeat (5) @(negedge clk);
        for (int c = 0; c < n; c++) begin
            if (c != 0) @(negedge clk);
            rec[c]   = ir_txd_out;
            tick16   = (c % TP == 0);
            uart_txd = (c < 10 * BTK * TP) ? fr[c / (BTK * TP)] : 1'b1;
        end
        @(negedge clk); tick16 = 1'b0;
        if (!fx) begin
            len_exp = 3 * TP; req = "R4";
        end else if ((1 << (sel + 1)) > 15 * TP) begin
            len_exp = 15 * TP; req = "R6";
        end else begin
            len_exp = 1 << (sel + 1); req = "R5";
        end
        if (inv) req = "R7";
        for (int k = 0; k < 10; k++) begin
            int s = k * BTK * TP + 1;
            int len = 0;
            if (!fr[k]) begin
                while (len < BTK * TP && rec[s + len] === 1'b1) len++;
                chk(rec[s - 1] === 1'b0 && len == len_exp, req,
                    "zero-bit pulse length", len, len_exp);
            end else begin
                for (int j = 0; j < BTK * TP; j++)
                    if (rec[s + j] !== 1'b0) len++;
                chk(len == 0, "R3", "high cycles in one-bit", len, 0);
            end
        end
    endtask

    // receive: tick every clock; pulses of width p at c0 and optionally c0+gap
    task automatic rx_case(input bit inv, input int p, input int gap,
                           input int len_exp, input string req);
        int c0 = 10, n = 90, first = -1, len = 0;
        @(negedge clk);
        cfg_rx_invert = inv; ir_rxd_in = inv; tick16 = 1'b1; uart_txd = 1'b1;
        repeat (4) @(negedge clk);
        for (int c = 0; c < n; c++) begin
            bit pl;
            if (c != 0) @(negedge clk);
            rec[c] = uart_rxd;
            pl = (c >= c0 && c < c0 + p) ||
                 (gap != 0 && c >= c0 + gap && c < c0 + gap + p);
            ir_rxd_in = pl ^ inv;
        end
        for (int c = 0; c < n; c++)
            if (first < 0 && rec[c] === 1'b0) first = c;
        if (first >= 0)
            while (first + len < n && rec[first + len] === 1'b0) len++;
        chk(first == c0 + 3, "R8", "uart_rxd fall latency", first - c0, 3);
        chk(len == len_exp, req, "uart_rxd low length", len, len_exp);
        chk(ir_txd_out === 1'b0, "R2", "ir_txd_out idle during receive",
            int'(ir_txd_out), 0);
    endtask

    initial begin
        rst_n = 1'b0; tick16 = 1'b0; uart_txd = 1'b1; ir_rxd_in = 1'b0;
        cfg_enable = 1'b1; cfg_rx_invert = 1'b0; cfg_fixed_pulse = 1'b0;
        cfg_pulse_sel = 3'd0;
        repeat (3) @(negedge clk);
        chk(ir_txd_out === 1'b0, "R2", "reset ir_txd_out", int'(ir_txd_out), 0);
        chk(uart_rxd === 1'b1, "R2", "reset uart_rxd", int'(uart_rxd), 1);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(ir_txd_out === 1'b0 && uart_rxd === 1'b1, "R2", "idle after reset",
            int'(ir_txd_out), 0);

        // normal 3/16 width, several data patterns
        tx_frame({1'b1, 8'h55, 1'b0}, 1'b0, 0, 1'b0);
        tx_frame({1'b1, 8'h00, 1'b0}, 1'b0, 0, 1'b0);
        tx_frame({1'b1, 8'hF0, 1'b0}, 1'b0, 0, 1'b0);
        // fixed widths, every selector code, consecutive zero bits included
        for (int s = 0; s < 8; s++)
            tx_frame({1'b1, 8'h0F, 1'b0}, 1'b1, s, 1'b0);
        // receive inversion must not alter transmit
        tx_frame({1'b1, 8'h55, 1'b0}, 1'b0, 0, 1'b1);
        tx_frame({1'b1, 8'h0F, 1'b0}, 1'b1, 2, 1'b1);

        rx_case(1'b0, 2, 0, 16, "R8");
        rx_case(1'b1, 3, 0, 16, "R7");
        rx_case(1'b0, 2, 16, 32, "R9");
        rx_case(1'b0, 1, 10, 26, "R9");

        // pass-through
        @(negedge clk);
        cfg_enable = 1'b0; tick16 = 1'b1;
        for (int v = 0; v < 8; v++) begin
            @(negedge clk);
            uart_txd = v[0]; ir_rxd_in = v[1]; cfg_rx_invert = v[2];
            #1;
            chk(ir_txd_out === uart_txd, "R1", "bypass tx",
                int'(ir_txd_out), int'(uart_txd));
            chk(uart_rxd === ir_rxd_in, "R1", "bypass rx",
                int'(uart_rxd), int'(ir_rxd_in));
        end
        done = 1;
        report();
    end
endmodule